// File: doc/BRIEF.md
# Page-Mode Burst DRAM Controller

This block bridges a synchronous processor bus to fast-page-mode DRAM built from one leaf or two 32-bit leaves. A bus cycle opens with an active-low request. The controller splits the word address into a leaf, a row and a column. It places the row and then the column on a 12-bit multiplexed address bus per leaf, and it pulses one RAS per leaf, one CAS per byte lane and one write enable per leaf. Each beat ends with a ready pulse. On that pulse the read data from the selected leaf is presented on the bus.

The controller leaves each leaf's row open after an access. A later access to the same row goes straight to the CAS pulse. An access to another row first closes the open row, then opens the new one. Bursts continue for as long as the burst input stays high. The beat address either counts up linearly or wraps inside an aligned group of four words. A free-running interval timer requests RAS-only refresh, and a warning output rises exactly one cycle before the refresh RAS.

Top module: `pmdram_ctrl`

## Requirements
- R1: While reset is held, and after reset, all RAS, CAS and write-enable strobes are high (inactive), and ready and the refresh warning are low until a request or the refresh interval elapses.
- R2: The word address maps to leaf and pins as follows. In single-leaf mode the column is `addr_i[7:0]` and the row is `addr_i[19:8]`. In two-leaf mode the leaf is `addr_i[0]` (1 = leaf B), the column is `addr_i[8:1]` and the row is `addr_i[20:9]`. The row is on the leaf's address bus when its RAS falls. The zero-extended column is on that bus during the CAS pulse.
- R3: In single-leaf mode, leaf B's RAS, CAS lanes and write enable stay high and its address bus stays zero.
- R4: A CAS pulse lasts one cycle. RAS of that leaf is low in the CAS cycle and in the two cycles before it. After a rising RAS, RAS stays high for at least two cycles.
- R5: An access to a leaf's open row causes no RAS fall. Any other access causes exactly one RAS activation.
- R6: On a write, CAS lane n of the leaf (`cas_n_o[4*leaf+n]`) is low exactly where `be_i[n]` is 1. The leaf's write enable is low in that cycle. On a read, all four lanes of the leaf are low and the write enables stay high. The lanes of the other leaf stay high.
- R7: Written bytes are merged into DRAM, and a read returns the stored word on `rdata_o` while `rdy_o` is high.
- R8: A burst keeps adding beats while `burst_i` is high at the end of a beat. With `mod4_i` low the next word address is the current one plus 1. With it high, only bits [1:0] count, and they wrap.
- R9: `rfsh_warn_o` is high for exactly the cycle before a refresh RAS. The refresh RAS falls on leaf A, and also on leaf B in two-leaf mode, with all CAS lanes high. Refresh closes the open rows.
- R10: Refresh comes every `REF_INT` cycles. A pending refresh takes precedence over a waiting request, and it never falls between beats of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| il_i | input | 1 | Two-leaf mode when high |
| mod4_i | input | 1 | Wrap burst addresses within four words |
| req_ni | input | 1 | Bus request, active low, held until first ready |
| we_i | input | 1 | Write when high |
| burst_i | input | 1 | Burst continue |
| be_i | input | 4 | Byte enables for writes |
| addr_i | input | 21 | Word address |
| wdata_i | input | 32 | Write data for the current beat |
| rdata_o | output | 32 | Read data, valid with ready |
| rdy_o | output | 1 | Beat complete |
| ma_a_o | output | 12 | Leaf A multiplexed address |
| ma_b_o | output | 12 | Leaf B multiplexed address |
| ras_n_o | output | 2 | RAS per leaf, active low |
| cas_n_o | output | 8 | CAS per byte lane, leaf B in [7:4] |
| we_n_o | output | 2 | DRAM write enable per leaf, active low |
| dq_o | output | 32 | Data to DRAM |
| dq_a_i | input | 32 | Data from leaf A |
| dq_b_i | input | 32 | Data from leaf B |
| rfsh_warn_o | output | 1 | Refresh about to start |

## Verification
The refresh interval can expire while a request is already waiting, or while a burst is in progress. Back-to-back traffic with random bursts and short idle gaps keeps the request line busy across many refresh intervals, so both collisions occur. The bench tracks each refresh from the warning pulse, removes refresh activations from the page-hit count, checks that no refresh appears between the first and last beat of a burst, and checks that the access completed after a refresh is judged as a row miss.

// File: rtl/pmdram_pkg.sv
package pmdram_pkg;
  localparam int MA_W = 12;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHK, ST_PRE, ST_ACT, ST_CAS, ST_RPRE, ST_RRAS, ST_RREC
  } st_e;

  typedef struct packed {
    logic            leaf;
    logic [MA_W-1:0] row;
    logic [MA_W-1:0] col;
  } loc_t;
endpackage

// File: rtl/pmdram_addr_map.sv
module pmdram_addr_map import pmdram_pkg::*; #(
  parameter int COL_W = 8,
  localparam int AW = COL_W + MA_W + 1
) (
  input  logic [AW-1:0] addr_i,
  input  logic          il_i,
  output loc_t          loc_o
);
  always_comb begin
    if (il_i) begin
      loc_o.leaf = addr_i[0];
      loc_o.row  = addr_i[COL_W+1 +: MA_W];
      loc_o.col  = MA_W'(addr_i[1 +: COL_W]);
    end else begin
      loc_o.leaf = 1'b0;
      loc_o.row  = addr_i[COL_W +: MA_W];
      loc_o.col  = MA_W'(addr_i[0 +: COL_W]);
    end
  end
endmodule

// File: rtl/pmdram_burst_step.sv
module pmdram_burst_step #(
  parameter int AW = 21
) (
  input  logic [AW-1:0] addr_i,
  input  logic          mod4_i,
  output logic [AW-1:0] next_o
);
  always_comb begin
    if (mod4_i) next_o = {addr_i[AW-1:2], addr_i[1:0] + 2'd1};
    else        next_o = addr_i + AW'(1);
  end
endmodule

// File: rtl/pmdram_refresh_timer.sv
module pmdram_refresh_timer #(
  parameter int REF_INT = 200,
  localparam int CW = $clog2(REF_INT)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic pend_o
);
  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = (cnt_q == CW'(REF_INT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_o <= 1'b0;
    end else begin
      cnt_q  <= wrap ? '0 : cnt_q + CW'(1);
      pend_o <= wrap | (pend_o & ~ack_i);
    end
  end

  // R10: a raised request waits until serviced
  p_pend_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !ack_i) |=> pend_o);
endmodule

// File: rtl/pmdram_seq.sv
module pmdram_seq import pmdram_pkg::*; #(
  parameter int AW   = 21,
  parameter int TRCD = 2,
  parameter int TRP  = 2,
  parameter int TRAS = 3,
  localparam int CNT_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            il_i,
  input  logic            req_ni,
  input  logic            we_i,
  input  logic            burst_i,
  input  logic [3:0]      be_i,
  input  logic [AW-1:0]   addr_i,
  input  loc_t            loc_i,
  input  logic [AW-1:0]   nxt_i,
  input  logic            ref_pend_i,
  output logic            ref_ack_o,
  output logic [AW-1:0]   cur_o,
  output logic            rdy_o,
  output logic [1:0]      ras_n_o,
  output logic [7:0]      cas_n_o,
  output logic [1:0]      we_n_o,
  output logic [MA_W-1:0] ma_a_o,
  output logic [MA_W-1:0] ma_b_o,
  output logic            warn_o
);
  st_e             st_q;
  logic [CNT_W-1:0] cnt_q;
  logic            we_q, bst_q;
  logic [3:0]      be_q;
  logic [1:0]      open_v_q;
  logic [MA_W-1:0] open_row_q [2];
  logic [MA_W-1:0] ref_row_q;
  logic            hit;
  logic [3:0]      lanes;

  assign hit       = open_v_q[loc_i.leaf] && (open_row_q[loc_i.leaf] == loc_i.row);
  assign ref_ack_o = (st_q == ST_IDLE) && ref_pend_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= ST_IDLE;
      cnt_q         <= '0;
      cur_o         <= '0;
      we_q          <= 1'b0;
      bst_q         <= 1'b0;
      be_q          <= '0;
      open_v_q      <= '0;
      open_row_q[0] <= '0;
      open_row_q[1] <= '0;
      ref_row_q     <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (ref_pend_i) begin
            open_v_q <= '0;
            st_q     <= ST_RPRE;
          end else if (!req_ni) begin
            cur_o <= addr_i;
            we_q  <= we_i;
            be_q  <= be_i;
            bst_q <= burst_i;
            st_q  <= ST_CHK;
          end
        end
        ST_CHK: begin
          cnt_q <= '0;
          if (hit) begin
            st_q <= ST_CAS;
          end else if (open_v_q[loc_i.leaf]) begin
            open_v_q[loc_i.leaf] <= 1'b0;
            st_q <= ST_PRE;
          end else begin
            open_v_q[loc_i.leaf]   <= 1'b1;
            open_row_q[loc_i.leaf] <= loc_i.row;
            st_q <= ST_ACT;
          end
        end
        ST_PRE: begin
          if (cnt_q == CNT_W'(TRP - 1)) begin
            cnt_q <= '0;
            open_v_q[loc_i.leaf]   <= 1'b1;
            open_row_q[loc_i.leaf] <= loc_i.row;
            st_q <= ST_ACT;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        ST_ACT: begin
          if (cnt_q == CNT_W'(TRCD - 1)) begin
            cnt_q <= '0;
            st_q  <= ST_CAS;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        ST_CAS: begin
          if (bst_q && burst_i) begin
            cur_o <= nxt_i;
            st_q  <= ST_CHK;
          end else st_q <= ST_IDLE;
        end
        ST_RPRE: begin
          if (cnt_q == CNT_W'(TRP - 1)) begin
            cnt_q <= '0;
            st_q  <= ST_RRAS;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        ST_RRAS: begin
          if (cnt_q == CNT_W'(TRAS - 1)) begin
            cnt_q <= '0;
            st_q  <= ST_RREC;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        ST_RREC: begin
          if (cnt_q == CNT_W'(TRP - 1)) begin
            cnt_q     <= '0;
            ref_row_q <= ref_row_q + MA_W'(1);
            st_q      <= ST_IDLE;
          end else cnt_q <= cnt_q + CNT_W'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // strobes
  assign ras_n_o[0] = ~(open_v_q[0] | (st_q == ST_RRAS));
  assign ras_n_o[1] = ~(open_v_q[1] | ((st_q == ST_RRAS) & il_i));
  assign rdy_o      = (st_q == ST_CAS);
  assign warn_o     = (st_q == ST_RPRE) && (cnt_q == CNT_W'(TRP - 1));

  always_comb begin
    lanes   = we_q ? be_q : 4'hF;
    cas_n_o = '1;
    we_n_o  = '1;
    if (st_q == ST_CAS) begin
      if (loc_i.leaf) cas_n_o[7:4] = ~lanes;
      else            cas_n_o[3:0] = ~lanes;
      if (we_q) we_n_o[loc_i.leaf] = 1'b0;
    end
  end

  always_comb begin
    ma_a_o = '0;
    ma_b_o = '0;
    if (st_q == ST_RRAS) begin
      ma_a_o = ref_row_q;
      if (il_i) ma_b_o = ref_row_q;
    end else if (st_q != ST_IDLE && st_q != ST_RPRE && st_q != ST_RREC) begin
      if (loc_i.leaf) ma_b_o = (st_q == ST_ACT) ? loc_i.row : loc_i.col;
      else            ma_a_o = (st_q == ST_ACT) ? loc_i.row : loc_i.col;
    end
  end

  for (genvar l = 0; l < 2; l++) begin : g_leaf_chk
    // R4: RAS low for the CAS cycle and the two before it
    p_ras_before_cas_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cas_n_o[4*l +: 4] != 4'hF) |->
        (!ras_n_o[l] && !$past(ras_n_o[l]) && !$past(ras_n_o[l], 2)));
    // R4: CAS pulse is one cycle
    p_cas_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cas_n_o[4*l +: 4] != 4'hF) |=> (cas_n_o[4*l +: 4] == 4'hF));
    // R4: precharge of at least two cycles
    p_precharge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ras_n_o[l]) |=> ras_n_o[l]);
  end

  // R9: warning is followed by refresh RAS with CAS idle
  p_warn_lead_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_o |=> (!ras_n_o[0] && cas_n_o == 8'hFF));

  // R3: leaf B quiet in single-leaf mode
  p_single_leaf_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !il_i |-> (ras_n_o[1] && cas_n_o[7:4] == 4'hF && we_n_o[1] && ma_b_o == '0));
endmodule

// File: rtl/pmdram_ctrl.sv
module pmdram_ctrl import pmdram_pkg::*; #(
  parameter int COL_W   = 8,
  parameter int REF_INT = 200,
  localparam int AW = COL_W + MA_W + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            il_i,
  input  logic            mod4_i,
  input  logic            req_ni,
  input  logic            we_i,
  input  logic            burst_i,
  input  logic [3:0]      be_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o,
  output logic            rdy_o,
  output logic [MA_W-1:0] ma_a_o,
  output logic [MA_W-1:0] ma_b_o,
  output logic [1:0]      ras_n_o,
  output logic [7:0]      cas_n_o,
  output logic [1:0]      we_n_o,
  output logic [31:0]     dq_o,
  input  logic [31:0]     dq_a_i,
  input  logic [31:0]     dq_b_i,
  output logic            rfsh_warn_o
);
  loc_t          loc;
  logic [AW-1:0] cur, nxt;
  logic          pend, ack;

  pmdram_addr_map #(.COL_W(COL_W)) u_map (
    .addr_i(cur), .il_i(il_i), .loc_o(loc)
  );

  pmdram_burst_step #(.AW(AW)) u_step (
    .addr_i(cur), .mod4_i(mod4_i), .next_o(nxt)
  );

  pmdram_refresh_timer #(.REF_INT(REF_INT)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ack), .pend_o(pend)
  );

  pmdram_seq #(.AW(AW)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .il_i(il_i), .req_ni(req_ni),
    .we_i(we_i), .burst_i(burst_i), .be_i(be_i), .addr_i(addr_i),
    .loc_i(loc), .nxt_i(nxt), .ref_pend_i(pend), .ref_ack_o(ack),
    .cur_o(cur), .rdy_o(rdy_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
    .we_n_o(we_n_o), .ma_a_o(ma_a_o), .ma_b_o(ma_b_o), .warn_o(rfsh_warn_o)
  );

  assign rdata_o = loc.leaf ? dq_b_i : dq_a_i;
  assign dq_o    = wdata_i;
endmodule

// File: tb/pmdram_ctrl_test.sv
module pmdram_ctrl_test;
  localparam int COL_W = 8;
  localparam int REF_INT = 200;
  localparam int AW = 21;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic il = 0, mod4 = 0, req_n = 1, we = 0, burst = 0;
  logic [3:0] be = 0;
  logic [AW-1:0] addr = 0;
  logic [31:0] wdata = 0, rdata, dq_o, dq_a, dq_b;
  logic rdy, warn;
  logic [11:0] ma_a, ma_b;
  logic [1:0] ras_n, we_n;
  logic [7:0] cas_n;

  pmdram_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .il_i(il), .mod4_i(mod4), .req_ni(req_n),
    .we_i(we), .burst_i(burst), .be_i(be), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rdy_o(rdy), .ma_a_o(ma_a), .ma_b_o(ma_b),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .dq_o(dq_o),
    .dq_a_i(dq_a), .dq_b_i(dq_b), .rfsh_warn_o(warn)
  );

  int checks = 0, errors = 0;
  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [31:0] dmem [int];
  logic [31:0] rmem [int];
  logic [31:0] dq_rd [2];
  assign dq_a = dq_rd[0];
  assign dq_b = dq_rd[1];

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] b);
    for (int i = 0; i < 4; i++) if (b[i]) o[8*i +: 8] = n[8*i +: 8];
    return o;
  endfunction
  function automatic logic [31:0] drd(int k);
    return dmem.exists(k) ? dmem[k] : 32'h0;
  endfunction
  function automatic logic [31:0] rrd(int k);
    return rmem.exists(k) ? rmem[k] : 32'h0;
  endfunction
  function automatic int key(logic l, logic [11:0] row, logic [11:0] col);
    return (int'(l) << 24) | (int'(row) << 12) | int'(col);
  endfunction
  function automatic void phys(input logic [AW-1:0] a, input logic m,
                               output logic l, output logic [11:0] row, output logic [11:0] col);
    if (m) begin l = a[0]; row = a[20:9]; col = {4'h0, a[8:1]}; end
    else   begin l = 1'b0; row = a[19:8]; col = {4'h0, a[7:0]}; end
  endfunction
  function automatic logic [AW-1:0] nxt(logic [AW-1:0] a, logic m4);
    return m4 ? {a[AW-1:2], a[1:0] + 2'd1} : a + 1;
  endfunction
  function automatic logic [AW-1:0] mk(logic m);
    int r = $urandom % 3, c = $urandom % 256, l = $urandom % 2;
    return m ? AW'((r << 9) | (c << 1) | l) : AW'((r << 8) | c);
  endfunction

  // DRAM model and strobe monitor
  logic [1:0] prev_ras = 2'b11;
  logic prev_warn = 0;
  int cyc = 0, rf_cnt = 0, last_rf = -1;
  int acts [2] = '{0, 0};
  logic [11:0] mrow [2];
  bit exp_v [2] = '{0, 0};
  logic [11:0] exp_row [2];

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (prev_warn) begin
      chk(prev_ras[0] && !ras_n[0] && cas_n == 8'hFF, "R9 refresh RAS one cycle after warning",
          {22'h0, ras_n, cas_n}, {22'h0, 2'b10, 8'hFF});
      if (il) chk(prev_ras[1] && !ras_n[1], "R9 leaf B refresh RAS", {30'h0, ras_n}, 32'h0);
      if (last_rf >= 0)
        chk(cyc - last_rf >= REF_INT - 30 && cyc - last_rf <= REF_INT + 30,
            "R10 refresh interval", cyc - last_rf, REF_INT);
      last_rf = cyc;
      rf_cnt++;
      exp_v = '{0, 0};
    end
    for (int l = 0; l < 2; l++) begin
      logic [11:0] ma_l;
      logic [3:0]  ln;
      ma_l = l ? ma_b : ma_a;
      ln = cas_n[4*l +: 4];
      if (prev_ras[l] && !ras_n[l]) begin
        mrow[l] = ma_l;
        if (!prev_warn) acts[l]++;
      end
      if (ln != 4'hF) begin
        if (ras_n[l]) chk(0, "R4 CAS without RAS", {28'h0, ln}, 32'hF);
        if (!we_n[l]) dmem[key(l[0], mrow[l], ma_l)] = merge(drd(key(l[0], mrow[l], ma_l)), dq_o, ~ln);
        else          dq_rd[l] = drd(key(l[0], mrow[l], ma_l));
      end
    end
    prev_ras = ras_n;
    prev_warn = warn;
  end

  task automatic txn(logic w, logic [3:0] b, logic [AW-1:0] a0, int n);
    logic [AW-1:0] a;
    logic [31:0] wd, lanes;
    logic l;
    logic [11:0] row, col;
    logic [7:0] expc;
    int k = 0, rf0 = 0, tot;
    bit hit;
    @(negedge clk); #1;
    acts = '{0, 0};
    a = a0; wd = $urandom;
    req_n = 0; we = w; be = b; addr = a0; burst = (n > 1); wdata = wd;
    while (k < n) begin
      @(negedge clk); #1;
      if (rdy) begin
        phys(a, il, l, row, col);
        chk((l ? ma_b : ma_a) == col, k > 0 ? "R8 burst column" : "R2 column on pins",
            {20'h0, l ? ma_b : ma_a}, {20'h0, col});
        chk(mrow[l] == row, "R2 row at RAS fall", {20'h0, mrow[l]}, {20'h0, row});
        lanes = w ? {28'h0, b} : 32'hF;
        expc = l ? {~lanes[3:0], 4'hF} : {4'hF, ~lanes[3:0]};
        chk(cas_n == expc, "R6 CAS lanes", {24'h0, cas_n}, {24'h0, expc});
        chk(we_n == (w ? (l ? 2'b01 : 2'b10) : 2'b11), "R6 write enable", {30'h0, we_n},
            {30'h0, w ? (l ? 2'b01 : 2'b10) : 2'b11});
        if (!il) chk(ras_n[1] && cas_n[7:4] == 4'hF && we_n[1] && ma_b == 0,
                     "R3 leaf B idle", {ras_n, we_n, cas_n, 4'h0, ma_b}, 32'h0);
        hit = exp_v[l] && exp_row[l] == row;
        tot = acts[0] + acts[1];
        chk(tot == (hit ? 0 : 1), "R5 activation count", tot, hit ? 0 : 1);
        acts = '{0, 0};
        exp_v[l] = 1; exp_row[l] = row;
        if (w) rmem[key(l, row, col)] = merge(rrd(key(l, row, col)), wd, b);
        else chk(rdata == rrd(key(l, row, col)), "R7 read data", rdata, rrd(key(l, row, col)));
        if (k == 0) rf0 = rf_cnt;
        else chk(rf_cnt == rf0, "R10 no refresh inside burst", rf_cnt, rf0);
        k++;
        if (k == 1) req_n = 1;
        burst = (k < n);
        a = nxt(a, mod4);
        wd = $urandom; wdata = wd;
      end
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h0C0FFEE));
    repeat (3) @(negedge clk);
    chk(ras_n == 2'b11 && cas_n == 8'hFF && we_n == 2'b11 && !rdy && !warn,
        "R1 strobes idle in reset", {ras_n, cas_n, we_n, rdy, warn}, 32'h0);
    rst_n = 1;
    @(negedge clk); #1;
    chk(ras_n == 2'b11 && cas_n == 8'hFF && we_n == 2'b11 && !rdy && !warn,
        "R1 strobes idle after reset", {ras_n, cas_n, we_n, rdy, warn}, 32'h0);

    // single leaf, directed: miss, hit, byte write, row change
    txn(1, 4'hF, 21'h00105, 1);
    txn(0, 4'hF, 21'h00105, 1);
    txn(1, 4'b0010, 21'h00105, 1);
    txn(0, 4'hF, 21'h00105, 1);
    txn(0, 4'hF, 21'h00205, 1);
    txn(1, 4'hF, 21'h000FE, 4);   // crosses a row boundary
    txn(0, 4'hF, 21'h000FE, 4);
    for (int i = 0; i < 60; i++) begin
      mod4 = $urandom % 2;
      txn($urandom % 2, 4'($urandom % 16), mk(0), 1 + $urandom % 4);
      repeat ($urandom % 3) @(negedge clk);
    end

    // two leaves
    il = 1; mod4 = 1;
    txn(1, 4'hF, 21'h00207, 4);   // wraps 3,0,1,2
    txn(0, 4'hF, 21'h00204, 4);
    mod4 = 0;
    txn(1, 4'b1001, 21'h00300, 3);
    txn(0, 4'hF, 21'h00300, 3);
    for (int i = 0; i < 90; i++) begin
      mod4 = $urandom % 2;
      txn($urandom % 2, 4'($urandom % 16), mk(1), 1 + $urandom % 4);
      repeat ($urandom % 3) @(negedge clk);
    end
    chk(rf_cnt >= 3, "R9 refresh cycles observed", rf_cnt, 3);
    finish_run();
  end
endmodule